// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of activation rows by a weight matrix that is held inside a grid of multiply-accumulate cells. The grid has `ROWS` rows, one for each position along the inner dimension, and `COLS` columns, one for each output. Each cell keeps one signed weight. Software-side logic first writes the weight matrix one grid row per cycle through a row-select port. The block then raises a flag to show that the matrix is complete.

After that flag is raised, the caller presents one activation row per cycle, unskewed. The block delays activation element k by k cycles before it enters grid row k. Activations travel east from cell to cell, and partial sums travel south, one register per hop. Each column's finished dot product leaves the bottom edge one cycle after its western neighbour's, and a per-column valid bit marks it. Cycles where the input valid is low inject zeros and yield no valid output. The pipeline therefore accepts a new row on every cycle.

Top module: `wsa_array`

## Requirements
- R1: After reset, `load_done` is 0 and every bit of `out_valid` is 0.
- R2: When `wl_en` is high at a clock edge, weight w[r][n] for r = `wl_row` is taken from `wl_data[n*AW +: AW]` as a signed value for every column n. Weights not addressed keep their value.
- R3: `load_done` rises on the edge where row `ROWS-1` is written. It then stays high until reset, including across later weight writes.
- R4: An input row presented while `load_done` is 0 is discarded. It yields no `out_valid` pulse in any later cycle.
- R5: A row accepted at clock edge p yields the result for column n, with `out_valid[n]` high, exactly during the cycle that follows edge p + ROWS − 1 + n.
- R6: The column-n result equals the sum over k of a[k]·w[k][n], with all operands signed, as a PSW-bit two's-complement value on `out_data[n*PSW +: PSW]`.
- R7: Rows presented on consecutive cycles each yield their own result, one per column per cycle. An idle cycle between rows yields no extra valid pulse.
- R8: `out_valid[n]` is never high except in a cycle named by R5 for some accepted row.
- R9: Activation element k is taken from `in_row[k*AW +: AW]` and multiplies the weights of grid row k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wl_en | input | 1 | Weight row write enable |
| wl_row | input | RSW | Grid row written by this weight write |
| wl_data | input | COLS*AW | One signed weight per column, column n at bits n*AW |
| load_done | output | 1 | High once the last weight row has been written |
| in_valid | input | 1 | An activation row is presented this cycle |
| in_row | input | ROWS*AW | Activation row, element k at bits k*AW |
| out_valid | output | COLS | Per-column result valid |
| out_data | output | COLS*PSW | Per-column signed result, column n at bits n*PSW |

## Verification
The bench loads weights of all −128 and streams rows of −128 and +127. A design that truncated the product or the sum to operand width, or lost the sign extension, would return wrong sums for these largest magnitudes. Weights with a distinct value in every cell, streamed against activation rows with a single non-zero element, expose any swapped row, column or field position, because the output would show the wrong cell's weight. Rows sent before the load finishes must produce no valid pulse, so a design that ignores the load flag fails on an unexpected result. Every result is also tagged with the cycle on which it is due, so a skew line that is one stage too long or too short shows up as a late or early column even when the sum is correct.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

   // width of a select field able to address n items, never below one bit
   function automatic int sel_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   // bits needed so that n products of two w-bit signed values cannot overflow
   function automatic int acc_width(input int w, input int n);
      return 2 * w + sel_width(n) + 1;
   endfunction

endpackage

// File: rtl/wsa_pe.sv
// One multiply-accumulate cell: a resident weight and a registered partial sum.
module wsa_pe #(
   parameter int AW  = 8,
   parameter int PSW = 20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  w_we,
   input  logic signed [AW-1:0]  w_din,
   input  logic signed [AW-1:0]  a_in,
   input  logic signed [PSW-1:0] psum_in,
   output logic signed [PSW-1:0] psum_out
);
   logic signed [AW-1:0]    w_q;
   logic signed [2*AW-1:0]  prod;
   logic signed [PSW-1:0]   prod_ext;

   always_comb begin
      prod     = a_in * w_q;
      prod_ext = PSW'(prod);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q      <= '0;
         psum_out <= '0;
      end else begin
         if (w_we) w_q <= w_din;
         psum_out <= psum_in + prod_ext;
      end
   end
endmodule

// File: rtl/wsa_skew.sv
// Input skew: grid row k sees activation element k delayed by k cycles.
module wsa_skew #(
   parameter int ROWS = 4,
   parameter int AW   = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 accept,
   input  logic [ROWS*AW-1:0]   in_row,
   output logic [ROWS*AW-1:0]   skew_row
);
   logic [ROWS*AW-1:0] gated;

   assign gated = accept ? in_row : '0;

   for (genvar k = 0; k < ROWS; k++) begin : g_row
      if (k == 0) begin : g_direct
         assign skew_row[0 +: AW] = gated[0 +: AW];
      end else begin : g_delay
         logic [AW-1:0] dl [0:k-1];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < k; s++) dl[s] <= '0;
            end else begin
               dl[0] <= gated[k*AW +: AW];
               for (int s = 1; s < k; s++) dl[s] <= dl[s-1];
            end
         end
         assign skew_row[k*AW +: AW] = dl[k-1];
      end
   end
endmodule

// File: rtl/wsa_ctrl.sv
// Sequencing: load-complete flag, input acceptance and per-column valid timing.
module wsa_ctrl #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter int RSW  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wl_en,
   input  logic [RSW-1:0]  wl_row,
   input  logic            in_valid,
   output logic            load_done,
   output logic            accept,
   output logic [COLS-1:0] col_valid
);
   localparam int DEPTH = ROWS + COLS - 1;
   localparam logic [RSW-1:0] LAST_ROW = RSW'(ROWS - 1);

   logic [DEPTH-1:0] vpipe;
   logic             last_wr;

   assign last_wr = wl_en && (wl_row == LAST_ROW);
   assign accept  = in_valid && load_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_done <= 1'b0;
         vpipe     <= '0;
      end else begin
         if (last_wr) load_done <= 1'b1;
         vpipe <= {vpipe[DEPTH-2:0], accept};
      end
   end

   for (genvar n = 0; n < COLS; n++) begin : g_vld
      assign col_valid[n] = vpipe[ROWS - 1 + n];
   end

   assert_load_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);

   assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      last_wr |=> load_done);
endmodule

// File: rtl/wsa_array.sv
// Weight-stationary systolic grid: ROWS x COLS cells, activations east, sums south.
module wsa_array #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter int AW   = 8,
   parameter int PSW  = 20,
   localparam int RSW = wsa_pkg::sel_width(ROWS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wl_en,
   input  logic [RSW-1:0]       wl_row,
   input  logic [COLS*AW-1:0]   wl_data,
   output logic                 load_done,
   input  logic                 in_valid,
   input  logic [ROWS*AW-1:0]   in_row,
   output logic [COLS-1:0]      out_valid,
   output logic [COLS*PSW-1:0]  out_data
);
   localparam int SAFE_PSW = wsa_pkg::acc_width(AW, ROWS);

   if (ROWS < 2) begin : g_bad_rows
      $error("wsa_array: ROWS must be at least 2");
   end
   if (COLS < 1) begin : g_bad_cols
      $error("wsa_array: COLS must be at least 1");
   end
   if (AW < 2) begin : g_bad_aw
      $error("wsa_array: AW must be at least 2");
   end
   if (PSW < 2 * AW) begin : g_bad_psw
      $error("wsa_array: PSW must hold a full product");
   end
   if (PSW < SAFE_PSW - 1) begin : g_note_psw
      // sums may wrap for extreme operands; result stays two's complement
   end

   logic                 accept;
   logic [ROWS*AW-1:0]   skew_row;
   logic signed [AW-1:0]  a_h  [ROWS][COLS];
   logic signed [PSW-1:0] ps_v [ROWS+1][COLS];

   wsa_ctrl #(.ROWS(ROWS), .COLS(COLS), .RSW(RSW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wl_en(wl_en), .wl_row(wl_row),
      .in_valid(in_valid), .load_done(load_done), .accept(accept),
      .col_valid(out_valid));

   wsa_skew #(.ROWS(ROWS), .AW(AW)) u_skew (
      .clk(clk), .rst_n(rst_n), .accept(accept), .in_row(in_row),
      .skew_row(skew_row));

   for (genvar k = 0; k < ROWS; k++) begin : g_r
      logic row_we;
      assign row_we = wl_en && (wl_row == RSW'(k));
      assign a_h[k][0] = skew_row[k*AW +: AW];

      for (genvar n = 0; n < COLS; n++) begin : g_c
         if (n < COLS - 1) begin : g_east
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) a_h[k][n+1] <= '0;
               else        a_h[k][n+1] <= a_h[k][n];
            end
         end

         wsa_pe #(.AW(AW), .PSW(PSW)) u_pe (
            .clk(clk), .rst_n(rst_n), .w_we(row_we),
            .w_din(wl_data[n*AW +: AW]), .a_in(a_h[k][n]),
            .psum_in(ps_v[k][n]), .psum_out(ps_v[k+1][n]));
      end
   end

   for (genvar n = 0; n < COLS; n++) begin : g_edge
      assign ps_v[0][n] = '0;
      assign out_data[n*PSW +: PSW] = ps_v[ROWS][n];

      if (n > 0) begin : g_lag
         assert_col_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[n] |-> $past(out_valid[n-1]));
      end
   end

   assert_gate_before_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !load_done |-> (out_valid == '0));

   assert_valid_needs_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[0] |-> load_done);
endmodule

// File: tb/sim_wsa_array.sv
module sim_wsa_array;
   localparam int ROWS = 4;
   localparam int COLS = 4;
   localparam int AW   = 8;
   localparam int PSW  = 20;
   localparam int RSW  = 2;
   localparam int CLK_PERIOD = 10;
   localparam int QD   = 512;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                wl_en = 1'b0;
   logic [RSW-1:0]      wl_row = '0;
   logic [COLS*AW-1:0]  wl_data = '0;
   logic                load_done;
   logic                in_valid = 1'b0;
   logic [ROWS*AW-1:0]  in_row = '0;
   logic [COLS-1:0]     out_valid;
   logic [COLS*PSW-1:0] out_data;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   int wm   [ROWS][COLS];
   int arow [ROWS];
   int qv   [COLS][QD];
   int qt   [COLS][QD];
   int qh   [COLS];
   int qtl  [COLS];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wsa_array #(.ROWS(ROWS), .COLS(COLS), .AW(AW), .PSW(PSW)) u0 (
      .clk(clk), .rst_n(rst_n), .wl_en(wl_en), .wl_row(wl_row),
      .wl_data(wl_data), .load_done(load_done), .in_valid(in_valid),
      .in_row(in_row), .out_valid(out_valid), .out_data(out_data));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int rnd8();
      logic signed [7:0] t;
      t = 8'($urandom);
      return int'(t);
   endfunction

   // monitor: every valid output must match the oldest due entry of its column
   always @(negedge clk) begin
      if (rst_n) begin
         for (int n = 0; n < COLS; n++) begin
            if (qh[n] != qtl[n] && qt[n][qh[n] % QD] < cyc) begin
               check(1'b0, "R5 missed result", 0, qv[n][qh[n] % QD]);
               qh[n]++;
            end
            if (out_valid[n]) begin
               if (qh[n] == qtl[n]) begin
                  check(1'b0, "R8 unexpected valid", n, -1);
               end else begin
                  int got;
                  got = int'($signed(out_data[n*PSW +: PSW]));
                  check(qt[n][qh[n] % QD] == cyc, "R5 result cycle", cyc, qt[n][qh[n] % QD]);
                  check(got == qv[n][qh[n] % QD], "R6 result value", got, qv[n][qh[n] % QD]);
                  qh[n]++;
               end
            end
         end
      end
   end

   task automatic load_row(input int r);
      wl_en  = 1'b1;
      wl_row = RSW'(r);
      for (int n = 0; n < COLS; n++) wl_data[n*AW +: AW] = AW'(wm[r][n]);
      @(negedge clk);
      wl_en = 1'b0;
   endtask

   // present arow for one cycle; expected results queued when push is set
   task automatic send_row(input bit push);
      if (push) begin
         for (int n = 0; n < COLS; n++) begin
            int s = 0;
            for (int k = 0; k < ROWS; k++) s += arow[k] * wm[k][n];
            qv[n][qtl[n] % QD] = s;
            qt[n][qtl[n] % QD] = cyc + ROWS + n;
            qtl[n]++;
         end
      end
      in_valid = 1'b1;
      for (int k = 0; k < ROWS; k++) in_row[k*AW +: AW] = AW'(arow[k]);
      @(negedge clk);
      in_valid = 1'b0;
      in_row   = AW'($urandom) == 0 ? '0 : ROWS*AW'({$urandom});
   endtask

   task automatic idle(input int c);
      for (int i = 0; i < c; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int n = 0; n < COLS; n++) begin qh[n] = 0; qtl[n] = 0; end
      for (int k = 0; k < ROWS; k++) for (int n = 0; n < COLS; n++) wm[k][n] = 0;

      idle(3);
      check(load_done == 1'b0, "R1 load_done after reset", int'(load_done), 0);
      check(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
      rst_n = 1'b1;
      idle(1);

      // R4: rows before the weight load are dropped
      for (int i = 0; i < 3; i++) begin
         for (int k = 0; k < ROWS; k++) arow[k] = rnd8();
         send_row(1'b0);
      end
      begin
         bit seen = 1'b0;
         for (int i = 0; i < ROWS + COLS + 2; i++) begin
            if (out_valid != '0) seen = 1'b1;
            @(negedge clk);
         end
         check(!seen, "R4 no output before load", int'(seen), 0);
      end

      // R3 + extreme weights
      for (int k = 0; k < ROWS; k++) for (int n = 0; n < COLS; n++) wm[k][n] = -128;
      for (int r = 0; r < ROWS; r++) begin
         load_row(r);
         if (r < ROWS - 1)
            check(load_done == 1'b0, "R3 load_done low mid-load", int'(load_done), 0);
         else
            check(load_done == 1'b1, "R3 load_done after last row", int'(load_done), 1);
      end

      // R6 corner magnitudes, R7 back to back
      for (int k = 0; k < ROWS; k++) arow[k] = -128;
      send_row(1'b1);
      for (int k = 0; k < ROWS; k++) arow[k] = 127;
      send_row(1'b1);
      for (int k = 0; k < ROWS; k++) arow[k] = 0;
      send_row(1'b1);
      for (int k = 0; k < ROWS; k++) arow[k] = (k % 2) ? 127 : -128;
      send_row(1'b1);
      idle(ROWS + COLS + 2);

      // R2 / R9 field positions: distinct weight per cell, one-hot activations
      for (int k = 0; k < ROWS; k++)
         for (int n = 0; n < COLS; n++)
            wm[k][n] = ((n % 2) ? -1 : 1) * (k * COLS + n + 1);
      for (int r = ROWS - 1; r >= 0; r--) load_row(r);
      check(load_done == 1'b1, "R3 load_done holds on reload", int'(load_done), 1);
      for (int j = 0; j < ROWS; j++) begin
         for (int k = 0; k < ROWS; k++) arow[k] = (k == j) ? 3 : 0;
         send_row(1'b1);
      end
      idle(ROWS + COLS + 2);

      // random weights and rows with random gaps
      for (int k = 0; k < ROWS; k++) for (int n = 0; n < COLS; n++) wm[k][n] = rnd8();
      for (int r = 0; r < ROWS; r++) load_row(r);
      for (int i = 0; i < 80; i++) begin
         for (int k = 0; k < ROWS; k++) arow[k] = rnd8();
         send_row(1'b1);
         if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
      end
      idle(ROWS + COLS + 2);

      // R7: every queued result was delivered
      for (int n = 0; n < COLS; n++)
         check(qh[n] == qtl[n], "R7 all results delivered", qh[n], qtl[n]);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule